// File: doc/BRIEF.md
# Flash Read-Configuration Command Decoder

This block is the command front end of a NOR-style flash device that holds a 16-bit read configuration word. The word sets up the burst read path: synchronous or asynchronous reads, first-access latency, WAIT polarity and timing, data hold, burst order, clock edge and burst length. The block watches host write cycles and decodes the command byte on the data lines. A setup code followed by a confirm code loads the configuration word from the low sixteen address lines. The block tracks the current read mode and presents the matching read word for the current address.

A write cycle lasts as long as chip enable, write strobe and address-valid are all high. Address and command are sampled on every clock of the cycle. When any of the three strobes falls, the command takes effect using the last values sampled inside the cycle. The configuration word can only be read back through identifier space. The programming-voltage input has no effect on any command.

Top module: `flash_cfg_cmd`

## Requirements
- R1: After reset, cfg_o is 16'hBFCF and mode_o is 0 (read-array).
- R2: A write cycle is open while ce_i, we_i and adv_i are all high. The command acts only when the first of them falls, and it uses the address and data sampled on the last clock of the open cycle. Values present when a strobe falls are ignored, and so is a cycle that is still open.
- R3: A write of 8'h60 followed by a write of 8'h03 loads cfg_o from addr_i of the confirm write, with reserved bits cleared. The setup write's address is discarded. Afterwards mode_o is 0.
- R4: If the write after 8'h60 carries any code other than 8'h03, cfg_o is unchanged and mode_o returns to 0.
- R5: Bits 14, 5 and 4 of cfg_o are always zero. All other bits are kept as written: 15 read mode, 13:11 latency, 10 WAIT polarity, 9 data hold, 8 WAIT timing, 7 burst order, 6 clock edge, 3 wrap, 2:0 burst length.
- R6: 8'h90 selects identifier mode (mode_o = 1). In this mode rd_data_o returns MFR_ID at offset addr_i[7:0] = 8'h00, DEV_ID at 8'h01, cfg_o at 8'h05, and zero at any other offset.
- R7: 8'hFF selects read-array mode (mode_o = 0), in which rd_data_o is ARRAY_FILL.
- R8: 8'h70 selects status mode (mode_o = 2). While mode_o is 2 or 3, rd_data_o is STATUS_WORD.
- R9: The configuration load behaves the same with vpp_i low or high.
- R10: mode_o is 3 between a setup write and the following write. In modes 0, 1 and 2, a code other than FF, 90, 70 or 60 leaves mode_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| we_i | input | 1 | Write strobe, active high |
| adv_i | input | 1 | Address valid, active high |
| vpp_i | input | 1 | Programming-voltage good level (no effect) |
| addr_i | input | 16 | Address bus; carries the configuration value on command writes |
| data_i | input | 8 | Command byte |
| rd_data_o | output | 16 | Read word for the current mode and address |
| mode_o | output | 2 | 0 read-array, 1 identifier, 2 status, 3 awaiting confirm |
| cfg_o | output | 16 | Configuration word to the burst read logic |

## Verification
The bench uses the default parameters: MFR_ID 16'h0089, DEV_ID 16'h8810, ARRAY_FILL 16'hFFFF and STATUS_WORD 16'h0080. These four values differ from each other and from the reset configuration word, so a read from the wrong mode or the wrong identifier offset shows up as a wrong value. Write cycles are closed by each of the three strobes in turn, and the bus lines change on the same clock that the strobe falls. Captured values that come from outside the open cycle can therefore be seen at the outputs.

// File: rtl/flash_cfg_cmd.sv
module flash_cfg_cmd #(
  parameter logic [15:0] MFR_ID      = 16'h0089,
  parameter logic [15:0] DEV_ID      = 16'h8810,
  parameter logic [15:0] ARRAY_FILL  = 16'hFFFF,
  parameter logic [15:0] STATUS_WORD = 16'h0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_i,
  input  logic        we_i,
  input  logic        adv_i,
  input  logic        vpp_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  output logic [15:0] rd_data_o,
  output logic [1:0]  mode_o,
  output logic [15:0] cfg_o
);

  localparam logic [15:0] CFG_KEEP  = 16'hBFCF;
  localparam logic [15:0] CFG_RESET = 16'hBFCF;
  localparam logic [1:0]  M_ARRAY = 2'd0, M_ID = 2'd1, M_STAT = 2'd2, M_SETUP = 2'd3;
  localparam logic [7:0]  C_ARRAY = 8'hFF, C_ID = 8'h90, C_STAT = 8'h70;
  localparam logic [7:0]  C_SETUP = 8'h60, C_CONFIRM = 8'h03;

  logic        wr_open, wr_open_q, wr_end;
  logic [15:0] lat_addr;
  logic [7:0]  lat_cmd;
  logic [1:0]  mode_q, mode_d;
  logic [15:0] cfg_q, cfg_d;
  logic        vpp_unused;

  assign vpp_unused = vpp_i;
  assign wr_open = ce_i & we_i & adv_i;
  assign wr_end  = wr_open_q & ~wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open_q <= 1'b0;
      lat_addr  <= '0;
      lat_cmd   <= '0;
    end else begin
      wr_open_q <= wr_open;
      if (wr_open) begin
        lat_addr <= addr_i;
        lat_cmd  <= data_i;
      end
    end
  end

  always_comb begin
    mode_d = mode_q;
    cfg_d  = cfg_q;
    if (wr_end) begin
      if (mode_q == M_SETUP) begin
        mode_d = M_ARRAY;
        if (lat_cmd == C_CONFIRM) cfg_d = lat_addr & CFG_KEEP;
      end else begin
        case (lat_cmd)
          C_ARRAY: mode_d = M_ARRAY;
          C_ID:    mode_d = M_ID;
          C_STAT:  mode_d = M_STAT;
          C_SETUP: mode_d = M_SETUP;
          default: mode_d = mode_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ARRAY;
      cfg_q  <= CFG_RESET;
    end else begin
      mode_q <= mode_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    case (mode_q)
      M_ARRAY: rd_data_o = ARRAY_FILL;
      M_ID: begin
        case (addr_i[7:0])
          8'h00:   rd_data_o = MFR_ID;
          8'h01:   rd_data_o = DEV_ID;
          8'h05:   rd_data_o = cfg_q;
          default: rd_data_o = '0;
        endcase
      end
      default: rd_data_o = STATUS_WORD;
    endcase
  end

  assign mode_o = mode_q;
  assign cfg_o  = cfg_q;

endmodule

// File: rtl/flash_cfg_cmd_chk.sv
module flash_cfg_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_i,
  input logic        we_i,
  input logic        adv_i,
  input logic [15:0] addr_i,
  input logic [15:0] rd_data_o,
  input logic [1:0]  mode_o,
  input logic [15:0] cfg_o
);
  logic open_c;
  assign open_c = ce_i & we_i & adv_i;

  p_cfg_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o & 16'h4030) == 16'h0000);

  p_cfg_only_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(mode_o) == 2'd3);

  p_setup_exit_array_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 2'd3 && mode_o != 2'd3) |-> mode_o == 2'd0);

  p_mode_on_cycle_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> ($past(open_c, 2) && !$past(open_c)));

  p_id_offset_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && addr_i[7:0] == 8'h05) |-> rd_data_o == cfg_o);

  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1]) |-> $stable(rd_data_o) || $past(!mode_o[1]));
endmodule

bind flash_cfg_cmd flash_cfg_cmd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .we_i(we_i), .adv_i(adv_i),
  .addr_i(addr_i), .rd_data_o(rd_data_o), .mode_o(mode_o), .cfg_o(cfg_o)
);

// File: tb/test_flash_cfg_cmd.sv
module test_flash_cfg_cmd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_i = 1'b0, we_i = 1'b0, adv_i = 1'b0, vpp_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [15:0] rd_data_o, cfg_o;
  logic [1:0]  mode_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_cfg_cmd i_flash_cfg_cmd (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .we_i(we_i), .adv_i(adv_i),
    .vpp_i(vpp_i), .addr_i(addr_i), .data_i(data_i),
    .rd_data_o(rd_data_o), .mode_o(mode_o), .cfg_o(cfg_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // endsel: 0 drops we, 1 drops ce, 2 drops adv; bus lines change as the cycle closes
  task automatic wr(input logic [15:0] a, input logic [7:0] c, input int endsel);
    @(negedge clk);
    addr_i = a; data_i = c; ce_i = 1; we_i = 1; adv_i = 1;
    repeat (2) @(negedge clk);
    addr_i = 16'hDEAD; data_i = 8'hEE;
    case (endsel)
      1: ce_i = 0;
      2: adv_i = 0;
      default: we_i = 0;
    endcase
    @(negedge clk);
    ce_i = 0; we_i = 0; adv_i = 0; addr_i = '0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a);
    addr_i = a; #1;
  endtask

  task automatic t_reset;
    chk("R1 cfg", cfg_o, 16'hBFCF);
    chk("R1 mode", {14'd0, mode_o}, 16'd0);
    rd(16'h0005); chk("R7 array read", rd_data_o, 16'hFFFF);
  endtask

  task automatic t_ident;
    wr(16'h0000, 8'h90, 0);
    chk("R6 mode", {14'd0, mode_o}, 16'd1);
    rd(16'h0000); chk("R6 mfr", rd_data_o, 16'h0089);
    rd(16'h0001); chk("R6 dev", rd_data_o, 16'h8810);
    rd(16'h0005); chk("R6 cfg", rd_data_o, 16'hBFCF);
    rd(16'h0007); chk("R6 other", rd_data_o, 16'h0000);
    wr(16'h0000, 8'hFF, 0);
    chk("R7 mode", {14'd0, mode_o}, 16'd0);
    rd(16'h0005); chk("R7 fill", rd_data_o, 16'hFFFF);
  endtask

  task automatic t_load;
    wr(16'h00A1, 8'h60, 0);
    chk("R10 setup mode", {14'd0, mode_o}, 16'd3);
    rd(16'h0000); chk("R8 setup read", rd_data_o, 16'h0080);
    wr(16'h1234, 8'h03, 0);
    chk("R3 cfg", cfg_o, 16'h1204);
    chk("R3 mode", {14'd0, mode_o}, 16'd0);
    wr(16'h0000, 8'h90, 0);
    rd(16'h0005); chk("R6 readback", rd_data_o, 16'h1204);
  endtask

  task automatic t_abort;
    wr(16'hFFFF, 8'h60, 0);
    wr(16'hFFFF, 8'h50, 0);
    chk("R4 cfg", cfg_o, 16'h1204);
    chk("R4 mode", {14'd0, mode_o}, 16'd0);
  endtask

  task automatic t_reserved;
    wr(16'h0000, 8'h60, 0); wr(16'hFFFF, 8'h03, 0);
    chk("R5 ones", cfg_o, 16'hBFCF);
    wr(16'h0000, 8'h60, 0); wr(16'h4030, 8'h03, 0);
    chk("R5 reserved only", cfg_o, 16'h0000);
  endtask

  task automatic t_vpp;
    vpp_i = 1;
    wr(16'h0000, 8'h60, 0); wr(16'h8041, 8'h03, 0);
    chk("R9 vpp high", cfg_o, 16'h8041);
    vpp_i = 0;
    wr(16'h0000, 8'h60, 0); wr(16'h2008, 8'h03, 0);
    chk("R9 vpp low", cfg_o, 16'h2008);
  endtask

  task automatic t_strobes;
    wr(16'h0000, 8'h60, 1); wr(16'h0A0A, 8'h03, 1);
    chk("R2 ce end", cfg_o, 16'h0A0A);
    wr(16'h0000, 8'h60, 2); wr(16'h0C03, 8'h03, 2);
    chk("R2 adv end", cfg_o, 16'h0C03);
    @(negedge clk);
    addr_i = 16'h0000; data_i = 8'h90; ce_i = 1; we_i = 1; adv_i = 1;
    repeat (5) @(negedge clk);
    chk("R2 open cycle", {14'd0, mode_o}, 16'd0);
    we_i = 0; ce_i = 0; adv_i = 0;
    repeat (2) @(negedge clk);
    chk("R2 closed cycle", {14'd0, mode_o}, 16'd1);
  endtask

  task automatic t_status;
    wr(16'h0000, 8'h70, 0);
    chk("R8 mode", {14'd0, mode_o}, 16'd2);
    rd(16'h0005); chk("R8 read", rd_data_o, 16'h0080);
    wr(16'h0000, 8'h12, 0);
    chk("R10 unknown", {14'd0, mode_o}, 16'd2);
    wr(16'h0000, 8'hFF, 0);
    chk("R10 back", {14'd0, mode_o}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_ident; t_load; t_abort; t_reserved; t_vpp; t_strobes; t_status;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule